// File: doc/BRIEF.md
# Three-Camera Initial Matching Cost Stage

This block sits at the front of a stereo matching engine fed by three rectified grayscale cameras. One camera is the reference. A second camera is offset along the row direction. A third is offset along the column direction. On every clock the block takes one reference pixel, the pixel from the horizontal camera at the same row and `d` columns to the left, and the pixel from the vertical camera at the same column and `round(k·d)` rows above. It also takes the pixel's column, its row and the candidate disparity `d`. Line buffers outside the block supply the shifted neighbours already aligned with the reference pixel.

The block adds the two absolute intensity differences to form a matching cost, then turns the cost into a confidence value equal to one minus the cost divided by 512. The confidence is an unsigned fixed-point number with 9 fractional bits. When either shifted neighbour would lie outside the image, the block forces the confidence to zero and raises a flag. The datapath is a three-stage pipeline that accepts a new (pixel, disparity) pair on every clock. A valid strobe and an end-of-line marker travel through the pipeline in step with the data.

Top module: `stereo_cost_init`

## Requirements
- R1: For an in-image pair, `outCost` equals 512 − (|horPix − refPix| + |verPix − refPix|). It is a 10-bit unsigned value with 9 fractional bits, so 512 stands for 1.0.
- R2: The block accepts a new input on every clock with no stall. A burst of N consecutive valid inputs yields exactly N valid outputs.
- R3: If `col` < `disp`, the horizontal neighbour is outside the image. The result then has `outInvalid` = 1 and `outCost` = 0.
- R4: If `row` is less than the vertical offset, the vertical neighbour is outside the image. The result then has `outInvalid` = 1 and `outCost` = 0. The vertical offset is `disp`·KRATIO/2^KFRAC rounded to the nearest integer, with halves rounded up. With the default k = 1.0 the offset equals `disp`.
- R5: `outValid` and `outLast` reproduce `inValid` and (`inValid` and `inLast`) exactly three clocks later, aligned with the result of the same input.
- R6: While `rst` is high and after it is released, `outValid`, `outLast` and `outInvalid` are 0 until a valid input has passed the pipeline.
- R7: Whenever `outValid` is 0, both `outInvalid` and `outLast` are 0.
- R8: An in-image result lies between 2 and 512. Identical pixels give 512. A reference of 0 with both neighbours at 255 gives 2.
- R9: With k = 1.5 (KRATIO = 384, KFRAC = 8), disparity 1 has a vertical offset of 2 and disparity 3 has an offset of 5. Row 1 at disparity 1 and row 4 at disparity 3 are therefore outside the image, while row 5 at disparity 3 is inside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input pair present this clock |
| inLast | input | 1 | Input pair is the last of its line |
| refPix | input | 8 | Reference camera intensity |
| horPix | input | 8 | Horizontal camera intensity at (col−disp, row) |
| verPix | input | 8 | Vertical camera intensity at (col, row−round(k·disp)) |
| col | input | 10 | Column of the reference pixel |
| row | input | 9 | Row of the reference pixel |
| disp | input | 5 | Candidate disparity, 0 to 31 |
| outValid | output | 1 | Result present |
| outLast | output | 1 | Result is the last of its line |
| outInvalid | output | 1 | A neighbour was outside the image |
| outCost | output | 10 | Confidence, 9 fractional bits |

## Verification
The properties assume that `col`, `row` and `disp` are meaningful only while `inValid` is high, and that the shifted neighbour pixels arrive on the same clock as their reference pixel. The stimulus drives every input field on every clock, including idle ones, and draws columns and rows near zero often enough that both image-edge cases occur frequently. A second instance with k = 1.5 receives the same stream, so that the rounding of the scaled vertical offset is exercised next to the equal-baseline case.

// File: rtl/stereo_cost_pkg.sv
package stereo_cost_pkg;
  localparam int NSTAGE = 3;
  localparam int NCH    = 2;

  typedef struct packed {
    logic [NSTAGE-1:0] adv;
    logic              kill;
  } costStrobe_t;
endpackage

// File: rtl/stereo_cost_ctrl.sv
module stereo_cost_ctrl
  import stereo_cost_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int DISP_W = 5,
  parameter int KW     = 12,
  parameter int KFRAC  = 8,
  parameter int KRATIO = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [DISP_W-1:0] disp,
  output costStrobe_t       strobe,
  output logic              outValid,
  output logic              outLast,
  output logic              outInvalid
);
  localparam int PW = DISP_W + KW + 1;

  logic [PW-1:0]     scaled;
  logic              horMiss;
  logic              verMiss;
  logic [NSTAGE-1:0] vldQ;
  logic [NSTAGE-1:0] lastQ;
  logic [NSTAGE-1:0] missQ;

  // rounded vertical offset: (disp * k + half) >> KFRAC
  assign scaled  = PW'(disp) * PW'(KRATIO) + PW'(1 << (KFRAC - 1));
  assign horMiss = col < COL_W'(disp);
  assign verMiss = PW'(row) < (scaled >> KFRAC);

  always_ff @(posedge clk) begin
    if (rst) begin
      vldQ  <= '0;
      lastQ <= '0;
      missQ <= '0;
    end else begin
      vldQ  <= {vldQ[NSTAGE-2:0], inValid};
      lastQ <= {lastQ[NSTAGE-2:0], inValid & inLast};
      missQ <= {missQ[NSTAGE-2:0], inValid & (horMiss | verMiss)};
    end
  end

  assign strobe.adv  = {vldQ[NSTAGE-2:0], inValid};
  assign strobe.kill = missQ[NSTAGE-2];

  assign outValid   = vldQ[NSTAGE-1];
  assign outLast    = lastQ[NSTAGE-1];
  assign outInvalid = missQ[NSTAGE-1];
endmodule

// File: rtl/stereo_cost_dp.sv
module stereo_cost_dp
  import stereo_cost_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int SAD_W  = PIX_W + $clog2(NCH),
  localparam int COST_W = SAD_W + 1
) (
  input  logic              clk,
  input  costStrobe_t       strobe,
  input  logic [PIX_W-1:0]  refPix,
  input  logic [PIX_W-1:0]  nbrPix [NCH],
  output logic [COST_W-1:0] cost
);
  logic [PIX_W-1:0]  diffArr [NCH];
  logic [SAD_W-1:0]  sadNext;
  logic [SAD_W-1:0]  sadQ;
  logic [COST_W-1:0] costQ;

  for (genvar g = 0; g < NCH; g++) begin : chan
    logic [PIX_W-1:0] diffQ;
    always_ff @(posedge clk) begin
      if (strobe.adv[0]) begin
        diffQ <= (nbrPix[g] > refPix) ? nbrPix[g] - refPix : refPix - nbrPix[g];
      end
    end
    assign diffArr[g] = diffQ;
  end

  always_comb begin
    sadNext = '0;
    for (int i = 0; i < NCH; i++) begin
      sadNext = sadNext + SAD_W'(diffArr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.adv[1]) sadQ <= sadNext;
    if (strobe.adv[2]) begin
      costQ <= strobe.kill ? '0 : (COST_W'(1) << SAD_W) - COST_W'(sadQ);
    end
  end

  assign cost = costQ;
endmodule

// File: rtl/stereo_cost_init.sv
module stereo_cost_init
  import stereo_cost_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int DISP_N = 32,
  parameter int KW     = 12,
  parameter int KFRAC  = 8,
  parameter int KRATIO = 256,
  localparam int DISP_W = $clog2(DISP_N),
  localparam int COST_W = PIX_W + $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [PIX_W-1:0]  refPix,
  input  logic [PIX_W-1:0]  horPix,
  input  logic [PIX_W-1:0]  verPix,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [DISP_W-1:0] disp,
  output logic              outValid,
  output logic              outLast,
  output logic              outInvalid,
  output logic [COST_W-1:0] outCost
);
  costStrobe_t      strobe;
  logic [PIX_W-1:0] nbrPix [NCH];

  assign nbrPix[0] = horPix;
  assign nbrPix[1] = verPix;

  stereo_cost_ctrl #(
    .COL_W(COL_W), .ROW_W(ROW_W), .DISP_W(DISP_W),
    .KW(KW), .KFRAC(KFRAC), .KRATIO(KRATIO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .col(col), .row(row), .disp(disp), .strobe(strobe),
    .outValid(outValid), .outLast(outLast), .outInvalid(outInvalid)
  );

  stereo_cost_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .strobe(strobe), .refPix(refPix),
    .nbrPix(nbrPix), .cost(outCost)
  );
endmodule

// File: rtl/stereo_cost_init_chk.sv
module stereo_cost_init_chk #(
  parameter int PIX_W  = 8,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int DISP_W = 5,
  localparam int COST_W = PIX_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inLast,
  input logic [COL_W-1:0]  col,
  input logic [ROW_W-1:0]  row,
  input logic [DISP_W-1:0] disp,
  input logic              outValid,
  input logic              outLast,
  input logic              outInvalid,
  input logic [COST_W-1:0] outCost
);
  logic [2:0] vq, lq, hq;

  always_ff @(posedge clk) begin
    if (rst) begin
      vq <= '0; lq <= '0; hq <= '0;
    end else begin
      vq <= {vq[1:0], inValid};
      lq <= {lq[1:0], inValid & inLast};
      hq <= {hq[1:0], inValid & (col < COL_W'(disp))};
    end
  end

  // R5
  validAlign_chk: assert property (@(posedge clk) disable iff (rst) outValid == vq[2]);
  // R5
  lastAlign_chk: assert property (@(posedge clk) disable iff (rst) outLast == lq[2]);
  // R3
  horMiss_chk: assert property (@(posedge clk) disable iff (rst) hq[2] |-> (outValid && outInvalid));
  // R4
  missZero_chk: assert property (@(posedge clk) disable iff (rst) (outValid && outInvalid) |-> outCost == '0);
  // R8
  costRange_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outInvalid) |-> (outCost >= COST_W'(2) && outCost <= (COST_W'(1) << (PIX_W + 1))));
  // R7
  idleQuiet_chk: assert property (@(posedge clk) disable iff (rst) !outValid |-> (!outInvalid && !outLast));

  logic unusedRow;
  assign unusedRow = ^row;
endmodule

bind stereo_cost_init stereo_cost_init_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
  .col(col), .row(row), .disp(disp), .outValid(outValid),
  .outLast(outLast), .outInvalid(outInvalid), .outCost(outCost)
);

// File: tb/stereo_cost_init_tb.sv
module stereo_cost_init_tb;
  logic clk = 0;
  logic rst = 1;
  logic inValid = 0, inLast = 0;
  logic [7:0] refPix = 0, horPix = 0, verPix = 0;
  logic [9:0] col = 0;
  logic [8:0] row = 0;
  logic [4:0] disp = 0;
  logic oV0, oL0, oI0, oVK, oLK, oIK;
  logic [9:0] oC0, oCK;

  int checks = 0, fails = 0, vcount = 0;

  // expected pipeline: index 0 newest
  bit eV [3], eL [3], eI0 [3], eIK [3];
  int eC0 [3], eCK [3], eW0 [3], eWK [3];

  always #5 clk = ~clk;

  stereo_cost_init u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .refPix(refPix),
    .horPix(horPix), .verPix(verPix), .col(col), .row(row), .disp(disp),
    .outValid(oV0), .outLast(oL0), .outInvalid(oI0), .outCost(oC0));

  stereo_cost_init #(.KRATIO(384)) u_dutK (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .refPix(refPix),
    .horPix(horPix), .verPix(verPix), .col(col), .row(row), .disp(disp),
    .outValid(oVK), .outLast(oLK), .outInvalid(oIK), .outCost(oCK));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // 0 inside, 1 horizontal miss, 2 vertical miss
  function automatic int why(int c, int r, int d, int kr);
    int voff = (d * kr + 128) >> 8;
    if (c < d) return 1;
    if (r < voff) return 2;
    return 0;
  endfunction

  function automatic string tagOf(int w, bit kdut);
    if (w == 1) return "R3";
    if (w == 2) return kdut ? "R9" : "R4";
    return "R1";
  endfunction

  task automatic compareOut();
    if (eV[2]) begin
      check(oV0 == 1, "R5", oV0, 1);
      check(oL0 == eL[2], "R5", oL0, eL[2]);
      check(oI0 == eI0[2], tagOf(eW0[2], 0), oI0, eI0[2]);
      check(oC0 == eC0[2], tagOf(eW0[2], 0), oC0, eC0[2]);
      check(oIK == eIK[2], tagOf(eWK[2], 1), oIK, eIK[2]);
      check(oCK == eCK[2], tagOf(eWK[2], 1), oCK, eCK[2]);
    end else begin
      check(oV0 == 0, "R5", oV0, 0);
      check(oI0 == 0 && oL0 == 0, "R7", {oI0, oL0}, 0);
      check(oIK == 0 && oLK == 0, "R7", {oIK, oLK}, 0);
    end
    if (oV0) vcount++;
  endtask

  task automatic step(bit v, bit l, int rp, int hp, int vp, int c, int r, int d);
    int w0, wk, sad;
    @(negedge clk);
    compareOut();
    for (int i = 2; i > 0; i--) begin
      eV[i] = eV[i-1]; eL[i] = eL[i-1]; eI0[i] = eI0[i-1]; eIK[i] = eIK[i-1];
      eC0[i] = eC0[i-1]; eCK[i] = eCK[i-1]; eW0[i] = eW0[i-1]; eWK[i] = eWK[i-1];
    end
    w0 = why(c, r, d, 256);
    wk = why(c, r, d, 384);
    sad = absd(hp, rp) + absd(vp, rp);
    eV[0] = v; eL[0] = v & l;
    eW0[0] = w0; eWK[0] = wk;
    eI0[0] = v && (w0 != 0); eIK[0] = v && (wk != 0);
    eC0[0] = (w0 != 0) ? 0 : 512 - sad;
    eCK[0] = (wk != 0) ? 0 : 512 - sad;
    inValid = v; inLast = l; refPix = 8'(rp); horPix = 8'(hp); verPix = 8'(vp);
    col = 10'(c); row = 9'(r); disp = 5'(d);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) begin
      eV[i] = 0; eL[i] = 0; eI0[i] = 0; eIK[i] = 0;
      eC0[i] = 0; eCK[i] = 0; eW0[i] = 0; eWK[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R6
    check(oV0 == 0 && oL0 == 0 && oI0 == 0, "R6", {oV0, oL0, oI0}, 0);
    rst = 0;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check(oV0 == 0 && oI0 == 0, "R6", {oV0, oI0}, 0);
    // R8 extremes
    step(1, 0, 77, 77, 77, 40, 40, 5);
    step(1, 0, 0, 255, 255, 40, 40, 5);
    step(1, 1, 255, 0, 0, 40, 40, 31);
    // R3 horizontal edge and boundary
    step(1, 0, 10, 20, 30, 3, 40, 4);
    step(1, 0, 10, 20, 30, 4, 40, 4);
    // R4 vertical edge and boundary
    step(1, 0, 10, 20, 30, 40, 6, 7);
    step(1, 0, 10, 20, 30, 40, 7, 7);
    // R9 rounding with k = 1.5
    step(1, 0, 50, 60, 70, 40, 1, 1);
    step(1, 0, 50, 60, 70, 40, 2, 1);
    step(1, 0, 50, 60, 70, 40, 4, 3);
    step(1, 1, 50, 60, 70, 40, 5, 3);
    step(1, 0, 9, 9, 9, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    // R2 burst
    vcount = 0;
    for (int i = 0; i < 20; i++) step(1, i == 19, i * 7, i * 3, i * 11, 50, 50, i);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    check(vcount == 20, "R2", vcount, 20);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0, ($urandom % 8) == 0,
           $urandom % 256, $urandom % 256, $urandom % 256,
           $urandom % 64, $urandom % 64, $urandom % 32);
    end
    repeat (4) step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule